// File: doc/BRIEF.md
# Host-Bus Access Sequencer

This block converts one read or write request at a time from an internal requester into a cycle on an external parallel bus. Every cycle starts with a single-clock address phase and then runs a data phase. In multiplexed mode, the low address byte and the data share one set of pins, and the strobe pin gives an address-latch pulse. In separate-bus mode, the same strobe pin acts as an active-low select that frames both phases.

The read and write strobes each have their own polarity. Each direction has its own wait-state count and its own trim bit, and the trim removes exactly one clock from that direction's data phase. An external ready line can hold the cycle. It is sampled on every rising edge, and its active level can be inverted. Ready monitoring can be turned off. A delay setting of 1 to 3 clocks sets how long a sampled not-ready takes to freeze the sequencer. Read data is latched on the last data clock. A one-clock done pulse follows, in the clock after the strobes fall back to their inactive level.

Top module: `hbus_seq`

## Requirements
- R1: After reset the block is idle. done_o is low. rd_o and wr_o sit at their inactive levels, and ale_cs_o is inactive.
- R2: In multiplexed mode (cfg_mux_i=1), ale_cs_o gives an address-latch pulse exactly one clock long, in the clock after the request is taken. Its active level is 1 when cfg_ale_hi_i=1 and 0 when cfg_ale_hi_i=0. No read or write strobe is active during that clock.
- R3: In separate-bus mode (cfg_mux_i=0), ale_cs_o is driven low from the address clock through the last data clock, and is high at all other times.
- R4: rd_o is active-high when cfg_rd_hi_i=1 and active-low when it is 0. wr_o follows cfg_wr_hi_i in the same way. Only the strobe for the current direction is ever active.
- R5: The data phase (the clocks where the strobe is active) lasts 2 + ws − trim clocks. Reads use cfg_rd_ws_i and cfg_rd_trim_i. Writes use cfg_wr_ws_i and cfg_wr_trim_i.
- R6: In multiplexed mode, ad_o carries req_addr_i[7:0] with ad_oe_o=1 during the address clock. In the data phase it carries the write data with ad_oe_o=1 for a write, and ad_oe_o=0 for a read.
- R7: rdata_o holds the value of ad_i sampled on the last clock of a read's data phase.
- R8: done_o is high for exactly one clock, in the clock after the last strobe-active clock. Both strobes are inactive while done_o is high.
- R9: With cfg_rdy_en_i=1, each rising edge that samples ready not-asserted freezes the sequencer for one clock. The freeze takes effect d clocks after the sample, where d = cfg_rdy_dly_i and a value of 0 counts as 1. A freeze that falls in the address or data phase lengthens the access by one clock.
- R10: The ready input is asserted when it is 1 if cfg_rdy_inv_i=0, and asserted when it is 0 if cfg_rdy_inv_i=1.
- R11: With cfg_rdy_en_i=0, the ready input has no effect on the length of an access.
- R12: A request is taken only in idle. A request raised during an access is ignored: addr_o keeps the address of the access in progress, and no further cycle follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, taken only in idle |
| req_we_i | input | 1 | 1 for write, 0 for read |
| req_addr_i | input | ADDR_W | Access address |
| req_wdata_i | input | DATA_W | Write data |
| done_o | output | 1 | One-clock completion pulse |
| rdata_o | output | DATA_W | Latched read data |
| cfg_mux_i | input | 1 | 1 for shared address/data pins |
| cfg_rd_hi_i | input | 1 | Read strobe active level |
| cfg_wr_hi_i | input | 1 | Write strobe active level |
| cfg_ale_hi_i | input | 1 | Address-latch active level |
| cfg_rd_ws_i | input | WS_W | Read wait states |
| cfg_wr_ws_i | input | WS_W | Write wait states |
| cfg_rd_trim_i | input | 1 | Remove one read data clock |
| cfg_wr_trim_i | input | 1 | Remove one write data clock |
| cfg_rdy_en_i | input | 1 | Enable ready monitoring |
| cfg_rdy_inv_i | input | 1 | Ready is asserted when low |
| cfg_rdy_dly_i | input | DLY_W | Ready stall delay, 1 to 3 clocks |
| rdy_i | input | 1 | External ready |
| ale_cs_o | output | 1 | Address latch or framing select |
| rd_o | output | 1 | Read strobe |
| wr_o | output | 1 | Write strobe |
| addr_o | output | ADDR_W | Latched address |
| ad_o | output | DATA_W | Shared or data-only bus, driven value |
| ad_oe_o | output | 1 | Output enable for ad_o |
| ad_i | input | DATA_W | Bus input value |

## Verification
The length sweep runs every combination of bus mode, direction, wait count and trim. The unused direction is always given a different count and trim, so the measured length shows which register set was applied and whether the trim took exactly one clock. Read data on the bus changes on every strobe clock, which pins the capture to the last one. A stray request raised during the address clock shows whether the sequencer ignores requests while busy. The ready sweep holds ready off for two samples starting in the first data clock and steps the delay over 0 to 3, with data phases of two and three clocks. The access should lengthen only when the delay is shorter than the phase, which separates the delay settings from one another. The same pattern with inverted polarity, and once with monitoring disabled, checks the polarity bit and the enable.

// File: rtl/hbus_pkg.sv
package hbus_pkg;
  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_ADDR = 2'd1,
    S_DATA = 2'd2,
    S_DONE = 2'd3
  } hbus_state_e;
endpackage

// File: rtl/hbus_rdy_pipe.sv
module hbus_rdy_pipe #(
  parameter int DEPTH = 3,
  localparam int DLY_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rdy_i,
  input  logic             en_i,
  input  logic             inv_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic             stall_o
);
  logic [DEPTH-1:0] nr_q;
  logic [DLY_W-1:0] idx;

  // nr_q[k] = not-ready sampled k+1 edges ago
  generate
    if (DEPTH == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) nr_q <= '0;
        else         nr_q <= ~(rdy_i ^ inv_i);
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) nr_q <= '0;
        else         nr_q <= {nr_q[DEPTH-2:0], ~(rdy_i ^ inv_i)};
    end
  endgenerate

  always_comb begin
    if (dly_i == '0)                   idx = '0;
    else if (int'(dly_i) > DEPTH)      idx = DLY_W'(DEPTH - 1);
    else                               idx = dly_i - DLY_W'(1);
  end

  assign stall_o = en_i & nr_q[idx];
endmodule

// File: rtl/hbus_wait_cnt.sv
module hbus_wait_cnt #(
  parameter int W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  input  logic         dec_i,
  output logic [W-1:0] cnt_o,
  output logic         zero_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (load_i) cnt_o <= val_i;
    else if (dec_i)  cnt_o <= cnt_o - W'(1);
  end

  assign zero_o = (cnt_o == '0);
endmodule

// File: rtl/hbus_strobe.sv
module hbus_strobe (
  input  logic in_addr_i,
  input  logic in_data_i,
  input  logic we_i,
  input  logic mux_i,
  input  logic rd_hi_i,
  input  logic wr_hi_i,
  input  logic ale_hi_i,
  output logic ale_cs_o,
  output logic rd_o,
  output logic wr_o
);
  logic rd_act, wr_act, ale_act, cs_act;

  assign rd_act  = in_data_i & ~we_i;
  assign wr_act  = in_data_i & we_i;
  assign ale_act = mux_i & in_addr_i;
  assign cs_act  = ~mux_i & (in_addr_i | in_data_i);

  assign rd_o     = rd_hi_i ? rd_act : ~rd_act;
  assign wr_o     = wr_hi_i ? wr_act : ~wr_act;
  assign ale_cs_o = mux_i ? (ale_hi_i ? ale_act : ~ale_act) : ~cs_act;
endmodule

// File: rtl/hbus_seq.sv
module hbus_seq
  import hbus_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int WS_W      = 2,
  parameter int RDY_DEPTH = 3,
  localparam int DLY_W    = $clog2(RDY_DEPTH + 1),
  localparam int CNT_W    = WS_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              cfg_mux_i,
  input  logic              cfg_rd_hi_i,
  input  logic              cfg_wr_hi_i,
  input  logic              cfg_ale_hi_i,
  input  logic [WS_W-1:0]   cfg_rd_ws_i,
  input  logic [WS_W-1:0]   cfg_wr_ws_i,
  input  logic              cfg_rd_trim_i,
  input  logic              cfg_wr_trim_i,
  input  logic              cfg_rdy_en_i,
  input  logic              cfg_rdy_inv_i,
  input  logic [DLY_W-1:0]  cfg_rdy_dly_i,
  input  logic              rdy_i,
  output logic              ale_cs_o,
  output logic              rd_o,
  output logic              wr_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] ad_o,
  output logic              ad_oe_o,
  input  logic [DATA_W-1:0] ad_i
);
  localparam int AD_LO = (ADDR_W < DATA_W) ? ADDR_W : DATA_W;

  hbus_state_e       state_q, state_d;
  logic              we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              stall;
  logic [CNT_W-1:0]  cnt, load_val;
  logic              cnt_zero, cnt_load, cnt_dec;
  logic              in_addr, in_data, last_data;

  hbus_rdy_pipe #(.DEPTH(RDY_DEPTH)) u_rdy (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rdy_i  (rdy_i),
    .en_i   (cfg_rdy_en_i),
    .inv_i  (cfg_rdy_inv_i),
    .dly_i  (cfg_rdy_dly_i),
    .stall_o(stall)
  );

  // data clocks = 2 + ws - trim, counter runs that minus one down to zero
  assign load_val = we_q ? (CNT_W'(cfg_wr_ws_i) + CNT_W'(1) - CNT_W'(cfg_wr_trim_i))
                         : (CNT_W'(cfg_rd_ws_i) + CNT_W'(1) - CNT_W'(cfg_rd_trim_i));
  assign in_addr   = (state_q == S_ADDR);
  assign in_data   = (state_q == S_DATA);
  assign cnt_load  = in_addr & ~stall;
  assign cnt_dec   = in_data & ~stall & ~cnt_zero;
  assign last_data = in_data & ~stall & cnt_zero;

  hbus_wait_cnt #(.W(CNT_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(cnt_load),
    .val_i (load_val),
    .dec_i (cnt_dec),
    .cnt_o (cnt),
    .zero_o(cnt_zero)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE: if (req_i)     state_d = S_ADDR;
      S_ADDR: if (!stall)    state_d = S_DATA;
      S_DATA: if (last_data) state_d = S_DONE;
      S_DONE:                state_d = S_IDLE;
      default:               state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == S_IDLE && req_i) begin
        we_q    <= req_we_i;
        addr_q  <= req_addr_i;
        wdata_q <= req_wdata_i;
      end
      if (last_data && !we_q) rdata_q <= ad_i;
    end
  end

  hbus_strobe u_strb (
    .in_addr_i(in_addr),
    .in_data_i(in_data),
    .we_i     (we_q),
    .mux_i    (cfg_mux_i),
    .rd_hi_i  (cfg_rd_hi_i),
    .wr_hi_i  (cfg_wr_hi_i),
    .ale_hi_i (cfg_ale_hi_i),
    .ale_cs_o (ale_cs_o),
    .rd_o     (rd_o),
    .wr_o     (wr_o)
  );

  // shared bus: address low bits in the address clock when multiplexed
  always_comb begin
    ad_o    = wdata_q;
    ad_oe_o = we_q & (in_data | (in_addr & ~cfg_mux_i));
    if (cfg_mux_i && in_addr) begin
      ad_o            = '0;
      ad_o[AD_LO-1:0] = addr_q[AD_LO-1:0];
      ad_oe_o         = 1'b1;
    end
  end

  assign addr_o  = addr_q;
  assign rdata_o = rdata_q;
  assign done_o  = (state_q == S_DONE);
endmodule

// File: rtl/hbus_seq_chk.sv
module hbus_seq_chk
  import hbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input hbus_state_e       state_q,
  input logic              stall,
  input logic [CNT_W-1:0]  cnt,
  input logic              rd_o,
  input logic              wr_o,
  input logic              done_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic              cfg_rd_hi_i,
  input logic              cfg_wr_hi_i
);
  a_r2_addr_one_clock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_ADDR && !stall) |=> (state_q == S_DATA));

  a_r4_strobe_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !((rd_o == cfg_rd_hi_i) && (wr_o == cfg_wr_hi_i)));

  a_r8_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r8_done_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ((rd_o != cfg_rd_hi_i) && (wr_o != cfg_wr_hi_i)));

  a_r9_stall_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_DATA && stall) |=> (state_q == S_DATA && $stable(cnt)));

  a_r12_addr_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != S_IDLE) |=> $stable(addr_o));
endmodule

bind hbus_seq hbus_seq_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .state_q    (state_q),
  .stall      (stall),
  .cnt        (cnt),
  .rd_o       (rd_o),
  .wr_o       (wr_o),
  .done_o     (done_o),
  .addr_o     (addr_o),
  .cfg_rd_hi_i(cfg_rd_hi_i),
  .cfg_wr_hi_i(cfg_wr_hi_i)
);

// File: tb/tb_hbus_seq.sv
module tb_hbus_seq;
  logic        clk = 0, rst_n = 0;
  logic        req = 0, req_we = 0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        done;
  logic [7:0]  rdata;
  logic        mux = 0, rd_hi = 0, wr_hi = 0, ale_hi = 0;
  logic [1:0]  rd_ws = 0, wr_ws = 0;
  logic        rd_trim = 0, wr_trim = 0, rdy_en = 0, rdy_inv = 0;
  logic [1:0]  rdy_dly = 1;
  logic        rdy = 1;
  logic        ale_cs, rd, wr, ad_oe;
  logic [15:0] addr;
  logic [7:0]  ad_out, ad_in = '0;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  hbus_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .req_we_i(req_we),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .done_o(done), .rdata_o(rdata),
    .cfg_mux_i(mux), .cfg_rd_hi_i(rd_hi), .cfg_wr_hi_i(wr_hi), .cfg_ale_hi_i(ale_hi),
    .cfg_rd_ws_i(rd_ws), .cfg_wr_ws_i(wr_ws), .cfg_rd_trim_i(rd_trim),
    .cfg_wr_trim_i(wr_trim), .cfg_rdy_en_i(rdy_en), .cfg_rdy_inv_i(rdy_inv),
    .cfg_rdy_dly_i(rdy_dly), .rdy_i(rdy), .ale_cs_o(ale_cs), .rd_o(rd), .wr_o(wr),
    .addr_o(addr), .ad_o(ad_out), .ad_oe_o(ad_oe), .ad_i(ad_in)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle_wait(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic access(input bit we, input logic [15:0] a, input logic [7:0] wd,
                        input int k, input int exp_len);
    int len = 0, ale_n = 0, cs_n = 0, other_n = 0, cyc = 0, stall_left = k;
    int bus_bad = 0, stray = 0;
    bit started = 0, prev_s = 0, done_seen = 0, done_ok = 0, sa, oa;
    chk(rd == !rd_hi && wr == !wr_hi && !done, "R4 idle levels", {rd, wr}, {!rd_hi, !wr_hi});
    @(negedge clk);
    req = 1; req_we = we; req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_addr = ~a;  // stray request during the address clock (R12)
    if (mux) chk(ad_oe && ad_out == a[7:0], "R6 address on shared bus", ad_out, a[7:0]);
    while (!done_seen && cyc < 100) begin
      sa = we ? (wr == wr_hi) : (rd == rd_hi);
      oa = we ? (rd == rd_hi) : (wr == wr_hi);
      if (cyc == 0) chk(!sa, "R2 no strobe in address clock", sa, 0);
      if (mux && ale_cs == ale_hi) ale_n++;
      if (!mux && ale_cs == 1'b0) cs_n++;
      if (oa) other_n++;
      if (sa) begin
        len++;
        if (!we) ad_in = 8'hA0 + 8'(len);
        if (mux && (we ? !(ad_oe && ad_out == wd) : ad_oe)) bus_bad++;
        if (len == 1) started = 1;
      end
      if (started && stall_left > 0) begin
        rdy = rdy_inv;  // not-asserted level
        stall_left--;
      end else rdy = !rdy_inv;
      if (done) begin
        done_seen = 1;
        done_ok = prev_s && !sa;
      end
      prev_s = sa;
      cyc++;
      @(negedge clk);
      req = 0;
    end
    while (stall_left > 0) begin
      rdy = rdy_inv;
      stall_left--;
      @(negedge clk);
    end
    rdy = !rdy_inv;
    chk(done_seen && done_ok, "R8 done after strobes", done_ok, 1);
    chk(!done, "R8 done one clock", done, 0);
    chk(len == exp_len, k > 0 ? "R9 R10 stalled data length" : "R5 data length", len, exp_len);
    chk(other_n == 0, "R4 other strobe quiet", other_n, 0);
    if (mux) chk(ale_n == 1, "R2 latch pulse clocks", ale_n, 1);
    else     chk(cs_n == exp_len + 1, "R3 select framing clocks", cs_n, exp_len + 1);
    if (mux) chk(bus_bad == 0, "R6 data phase bus", bus_bad, 0);
    if (!we) chk(rdata == 8'hA0 + 8'(len), "R7 read capture", rdata, 8'hA0 + 8'(len));
    chk(addr == a, "R12 address held", addr, a);
    for (int i = 0; i < 6; i++) begin
      if ((rd == rd_hi) || (wr == wr_hi)) stray++;
      @(negedge clk);
    end
    chk(stray == 0, "R12 stray request ignored", stray, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    int idx = 0;
    int de, l;
    repeat (3) @(negedge clk);
    chk(!done && rd == 1'b1 && wr == 1'b1 && ale_cs == 1'b1, "R1 reset state",
        {done, rd, wr, ale_cs}, 4'b0111);
    rst_n = 1;
    idle_wait(2);
    // length, polarity and bus sweep
    for (int m = 0; m < 2; m++)
      for (int w = 0; w < 2; w++)
        for (int ws = 0; ws < 4; ws++)
          for (int t = 0; t < 2; t++) begin
            mux = m[0]; rd_hi = ws[0]; wr_hi = ws[1]; ale_hi = t[0] ^ m[0];
            rd_ws = w ? 2'(3 - ws) : 2'(ws); wr_ws = w ? 2'(ws) : 2'(3 - ws);
            rd_trim = w ? !t[0] : t[0]; wr_trim = w ? t[0] : !t[0];
            idle_wait(2);
            access(w[0], 16'h1234 ^ 16'(idx * 16'h0511), 8'h5A ^ 8'(idx * 7), 0, 2 + ws - t);
            idx++;
          end
    // ready delay / polarity sweep (R9, R10)
    mux = 0; rd_hi = 0; wr_hi = 0; rd_trim = 0; rdy_en = 1;
    for (int inv = 0; inv < 2; inv++)
      for (int d = 0; d < 4; d++)
        for (int ws = 0; ws < 2; ws++) begin
          rdy_inv = inv[0]; rdy = !inv[0]; rdy_dly = 2'(d); rd_ws = 2'(ws);
          idle_wait(5);
          de = (d == 0) ? 1 : d;
          l = 2 + ws;
          access(1'b0, 16'h0F00 + 16'(d), 8'h00, 2, l + ((de < l) ? 2 : 0));
        end
    // stalled multiplexed write
    mux = 1; ale_hi = 1; wr_ws = 2; wr_trim = 0; rdy_dly = 1; rdy_inv = 0; rdy = 1;
    idle_wait(5);
    access(1'b1, 16'hBEEF, 8'hC3, 3, 7);
    // monitoring disabled (R11)
    rdy_en = 0; mux = 0; rd_ws = 1; rd_trim = 0;
    idle_wait(5);
    access(1'b0, 16'h7777, 8'h00, 3, 3);
    chk(1'b1, "R11 disabled ready covered above", 0, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule